// File: doc/BRIEF.md
# Outgoing Packet Size Histogrammer

This block keeps two separate histograms of the sizes of packets leaving a network interface: one for the slow-control stream and one for the data stream. Each stream signals that a packet has been sent with a one-cycle done strobe and gives the packet length in bytes alongside it. The block works out which size bin the length belongs to and adds one to that bin's counter in the histogram for that stream.

Each histogram has 32 bins, each 2048 bytes wide. A length is binned by dividing it by 2048, and any quotient past the last bin is placed in the last bin. Software reads the counters over a simple register read port. The slow-control bins appear as one window of the register page and the data bins as another. A synchronous clear input empties both histograms at once.

Top module: `pkt_size_histo`

## Requirements
- R1: After the active-low reset, every counter in both histograms reads zero and `rd_data` is zero.
- R2: A packet of length L falls in bin floor(L / 2048). Bin 0 holds lengths 0 to 2047, bin 1 holds 2048 to 4095, and so on up to bin 31.
- R3: A length of 65536 bytes or more counts in bin 31.
- R4: Each done strobe adds exactly one to exactly one counter of its own stream's histogram. In a cycle with no strobe and no clear, no counter changes.
- R5: A counter that holds the all-ones value (0xFFFFFFFF at the default width `CNT_W`=32) keeps that value on further increments. It never wraps.
- R6: A read at page offset 0x60+k returns slow-control bin k, and a read at 0x80+k returns data bin k, for k from 0 to 31. A read at any other offset returns zero.
- R7: When `clr` is high at a clock edge, all 64 counters are zero after that edge, including any bin that a strobe in the same cycle would have incremented.
- R8: Strobes from both streams in the same cycle each increment their own histogram. This holds even when both pick the same bin index.
- R9: `rd_data` takes the addressed value one cycle after `rd_en`. The value is the one the counter held before any increment or clear on that same edge, and the increment itself is kept. While `rd_en` is low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| sc_done | input | 1 | Slow-control packet sent strobe |
| sc_len | input | LEN_W | Slow-control packet length in bytes |
| dt_done | input | 1 | Data packet sent strobe |
| dt_len | input | LEN_W | Data packet length in bytes |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Offset within the register page |
| rd_data | output | CNT_W | Read result, one cycle after `rd_en` |

## Verification
The functions that can coincide are a register read and a counter update, which is an increment from either stream or a clear, when both touch the same bin on the same edge. The bench drives strobes, clears and reads in the same cycles, both in directed cases aimed at the same bin and in a long random mix. It compares `rd_data` on every clock with a behavioural model. That model takes the read value before it applies that edge's updates, so a lost increment or a read that returns the post-update value both show up as a mismatch on a later read.

// File: rtl/pkt_histo_pkg.sv
// Package: shared types for the packet size histogrammer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pkt_histo_pkg;

    // Which histogram a read address selects, if any.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_SC   = 2'd1,
        RD_DT   = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/histo_bin_sel.sv
// Module: histo_bin_sel
// Maps a byte length to a bin index by dropping BIN_SHIFT low bits and
// clamping quotients beyond the last bin to NUM_BINS-1.
// Assumes LEN_W - BIN_SHIFT >= BIN_W.
module histo_bin_sel #(
    parameter int LEN_W     = 20,
    parameter int BIN_SHIFT = 11,
    parameter int NUM_BINS  = 32,
    parameter int BIN_W     = $clog2(NUM_BINS)
) (
    input  logic [LEN_W-1:0] len,
    output logic [BIN_W-1:0] bin
);
    localparam int Q_W = LEN_W - BIN_SHIFT;
    localparam logic [Q_W-1:0] LAST_Q = Q_W'(NUM_BINS - 1);

    logic [Q_W-1:0] quot;

    assign quot = len[LEN_W-1:BIN_SHIFT];

    // Select the bin, clamping oversize lengths to the last bin.
    always_comb begin
        if (quot > LAST_Q) begin
            bin = BIN_W'(NUM_BINS - 1);
        end else begin
            bin = quot[BIN_W-1:0];
        end
    end
endmodule

// File: rtl/histo_bank.sv
// Module: histo_bank
// One histogram: NUM_BINS saturating counters, one increment port, one
// combinational read port, synchronous clear with priority over increment.
// Assumes inc_bin is always below NUM_BINS.
module histo_bank #(
    parameter int NUM_BINS = 32,
    parameter int CNT_W    = 32,
    parameter int BIN_W    = $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [BIN_W-1:0] inc_bin,
    input  logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_val,
    output logic [CNT_W-1:0] cnt_o [NUM_BINS]
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NUM_BINS];

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        logic             hit;
        logic [CNT_W-1:0] val;

        assign hit = inc && (inc_bin == BIN_W'(b));

        // Hold one bin: reset, clear, or saturating increment.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val <= '0;
            end else if (clr) begin
                val <= '0;
            end else if (hit && (val != CNT_MAX)) begin
                val <= val + 1'b1;
            end
        end

        assign cnt[b] = val;
    end

    assign rd_val = cnt[rd_bin];
    assign cnt_o  = cnt;
endmodule

// File: rtl/histo_rd_dec.sv
// Module: histo_rd_dec
// Decodes a page offset into a histogram select and a bin index.
// Assumes the two windows of NUM_BINS entries do not overlap.
module histo_rd_dec
    import pkt_histo_pkg::*;
#(
    parameter int              NUM_BINS = 32,
    parameter int              ADDR_W   = 8,
    parameter int              BIN_W    = $clog2(NUM_BINS),
    parameter logic [ADDR_W-1:0] SC_BASE = 8'h60,
    parameter logic [ADDR_W-1:0] DT_BASE = 8'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output rd_sel_e           sel,
    output logic [BIN_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(NUM_BINS);

    logic [ADDR_W-1:0] sc_off;
    logic [ADDR_W-1:0] dt_off;

    assign sc_off = addr - SC_BASE;
    assign dt_off = addr - DT_BASE;

    // Pick the window the address falls in and its offset.
    always_comb begin
        sel = RD_NONE;
        idx = '0;
        if (sc_off < WIN) begin
            sel = RD_SC;
            idx = sc_off[BIN_W-1:0];
        end else if (dt_off < WIN) begin
            sel = RD_DT;
            idx = dt_off[BIN_W-1:0];
        end
    end
endmodule

// File: rtl/pkt_size_histo.sv
// Module: pkt_size_histo (top)
// Two packet size histograms (slow-control and data), each fed by a done
// strobe plus a byte length, read through a one-cycle-latency register port.
// Assumes strobes are single-cycle per packet; clr is synchronous.
module pkt_size_histo
    import pkt_histo_pkg::*;
#(
    parameter int                NUM_BINS  = 32,
    parameter int                CNT_W     = 32,
    parameter int                LEN_W     = 20,
    parameter int                BIN_SHIFT = 11,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SC_BASE   = 8'h60,
    parameter logic [ADDR_W-1:0] DT_BASE   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sc_done,
    input  logic [LEN_W-1:0]  sc_len,
    input  logic              dt_done,
    input  logic [LEN_W-1:0]  dt_len,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int BIN_W = $clog2(NUM_BINS);

    logic [BIN_W-1:0] sc_bin;
    logic [BIN_W-1:0] dt_bin;
    logic [BIN_W-1:0] rd_idx;
    rd_sel_e          rd_sel;
    logic [CNT_W-1:0] sc_rd_val;
    logic [CNT_W-1:0] dt_rd_val;
    logic [CNT_W-1:0] rd_next;
    logic [CNT_W-1:0] sc_cnts [NUM_BINS];
    logic [CNT_W-1:0] dt_cnts [NUM_BINS];

    histo_bin_sel #(
        .LEN_W(LEN_W), .BIN_SHIFT(BIN_SHIFT), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W)
    ) u_sc_bin (
        .len (sc_len),
        .bin (sc_bin)
    );

    histo_bin_sel #(
        .LEN_W(LEN_W), .BIN_SHIFT(BIN_SHIFT), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W)
    ) u_dt_bin (
        .len (dt_len),
        .bin (dt_bin)
    );

    histo_rd_dec #(
        .NUM_BINS(NUM_BINS), .ADDR_W(ADDR_W), .BIN_W(BIN_W),
        .SC_BASE(SC_BASE), .DT_BASE(DT_BASE)
    ) u_dec (
        .addr (rd_addr),
        .sel  (rd_sel),
        .idx  (rd_idx)
    );

    histo_bank #(
        .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .BIN_W(BIN_W)
    ) u_sc_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (sc_done),
        .inc_bin (sc_bin),
        .rd_bin  (rd_idx),
        .rd_val  (sc_rd_val),
        .cnt_o   (sc_cnts)
    );

    histo_bank #(
        .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .BIN_W(BIN_W)
    ) u_dt_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .inc     (dt_done),
        .inc_bin (dt_bin),
        .rd_bin  (rd_idx),
        .rd_val  (dt_rd_val),
        .cnt_o   (dt_cnts)
    );

    // Choose the read source from the decoded window.
    always_comb begin
        case (rd_sel)
            RD_SC:   rd_next = sc_rd_val;
            RD_DT:   rd_next = dt_rd_val;
            default: rd_next = '0;
        endcase
    end

    // Register the read result; hold it when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/pkt_histo_chk.sv
// Module: pkt_histo_chk
// Assertion checker for pkt_size_histo, attached by bind below. It watches
// the counter arrays and the read port from one cycle to the next.
module pkt_histo_chk #(
    parameter int                NUM_BINS = 32,
    parameter int                CNT_W    = 32,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SC_BASE  = 8'h60,
    parameter logic [ADDR_W-1:0] DT_BASE  = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              sc_done,
    input logic              dt_done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_data,
    input logic [CNT_W-1:0]  sc_cnts [NUM_BINS],
    input logic [CNT_W-1:0]  dt_cnts [NUM_BINS]
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [CNT_W-1:0] sc_prev [NUM_BINS];
    logic [CNT_W-1:0] dt_prev [NUM_BINS];
    logic prev_ok, clr_d, sc_done_d, dt_done_d;
    int   sc_nchg, dt_nchg, n_bad_step, n_nonzero, n_wrap;
    logic unmapped;

    // Remember last cycle's counters and controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ok   <= 1'b0;
            clr_d     <= 1'b0;
            sc_done_d <= 1'b0;
            dt_done_d <= 1'b0;
        end else begin
            prev_ok   <= 1'b1;
            clr_d     <= clr;
            sc_done_d <= sc_done;
            dt_done_d <= dt_done;
        end
        sc_prev <= sc_cnts;
        dt_prev <= dt_cnts;
    end

    // Summarise how the counters moved since last cycle.
    always_comb begin
        sc_nchg = 0; dt_nchg = 0; n_bad_step = 0; n_nonzero = 0; n_wrap = 0;
        for (int b = 0; b < NUM_BINS; b++) begin
            if (sc_cnts[b] != sc_prev[b]) sc_nchg++;
            if (dt_cnts[b] != dt_prev[b]) dt_nchg++;
            if (sc_cnts[b] != sc_prev[b] && sc_cnts[b] != sc_prev[b] + 1'b1) n_bad_step++;
            if (dt_cnts[b] != dt_prev[b] && dt_cnts[b] != dt_prev[b] + 1'b1) n_bad_step++;
            if (sc_cnts[b] != '0) n_nonzero++;
            if (dt_cnts[b] != '0) n_nonzero++;
            if (sc_prev[b] == ALL1 && sc_cnts[b] != ALL1) n_wrap++;
            if (dt_prev[b] == ALL1 && dt_cnts[b] != ALL1) n_wrap++;
        end
    end

    // Address outside both windows, computed in plain integers.
    assign unmapped = !((int'(rd_addr) >= int'(SC_BASE) && int'(rd_addr) < int'(SC_BASE) + NUM_BINS) ||
                        (int'(rd_addr) >= int'(DT_BASE) && int'(rd_addr) < int'(DT_BASE) + NUM_BINS));

    assert_one_bin_sc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !clr_d) |-> (sc_nchg <= (sc_done_d ? 1 : 0)));

    assert_one_bin_dt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !clr_d) |-> (dt_nchg <= (dt_done_d ? 1 : 0)));

    assert_step_of_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !clr_d) |-> (n_bad_step == 0));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !clr_d) |-> (n_wrap == 0));

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && clr_d) |-> (n_nonzero == 0));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && !rd_en) |=> $stable(rd_data));

    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rd_data == '0));
endmodule

bind pkt_size_histo pkt_histo_chk #(
    .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .SC_BASE(SC_BASE), .DT_BASE(DT_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .sc_done (sc_done),
    .dt_done (dt_done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sc_cnts (sc_cnts),
    .dt_cnts (dt_cnts)
);

// File: tb/pkt_size_histo_tb.sv
// Bench for pkt_size_histo: a behavioural model (integer arrays) is updated
// each clock and rd_data is compared with it on every cycle. The counter
// width is reduced so that saturation is reachable.
module pkt_size_histo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB     = 32;
    localparam int CW     = 6;
    localparam int LW     = 20;
    localparam int AW     = 8;
    localparam int CMAX   = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          sc_done = 1'b0;
    logic [LW-1:0] sc_len = '0;
    logic          dt_done = 1'b0;
    logic [LW-1:0] dt_len = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;

    int sc_m [NB];
    int dt_m [NB];
    int exp_rd = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_size_histo #(.NUM_BINS(NB), .CNT_W(CW), .LEN_W(LW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .sc_done(sc_done), .sc_len(sc_len),
        .dt_done(dt_done), .dt_len(dt_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int bin_of(int len);
        int q = len / 2048;
        return (q > NB - 1) ? NB - 1 : q;
    endfunction

    function automatic int model_read(int addr);
        if (addr >= 'h60 && addr < 'h60 + NB) return sc_m[addr - 'h60];
        if (addr >= 'h80 && addr < 'h80 + NB) return dt_m[addr - 'h80];
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare after it.
    task automatic cyc(string req, bit c, bit sd, int sl, bit dd, int dl, bit re, int ra);
        clr = c; sc_done = sd; sc_len = LW'(sl);
        dt_done = dd; dt_len = LW'(dl); rd_en = re; rd_addr = AW'(ra);
        @(posedge clk);
        if (re) exp_rd = model_read(ra);
        if (c) begin
            for (int b = 0; b < NB; b++) begin sc_m[b] = 0; dt_m[b] = 0; end
        end else begin
            if (sd && sc_m[bin_of(sl)] < CMAX) sc_m[bin_of(sl)]++;
            if (dd && dt_m[bin_of(dl)] < CMAX) dt_m[bin_of(dl)]++;
        end
        #(CLK_PERIOD/4);
        check(req, int'(rd_data), exp_rd);
        @(negedge clk);
    endtask

    task automatic rd(string req, int addr);
        cyc(req, 0, 0, 0, 0, 0, 1, addr);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin sc_m[b] = 0; dt_m[b] = 0; end
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        // R1: all bins zero after reset
        for (int k = 0; k < NB; k++) begin rd("R1", 'h60 + k); rd("R1", 'h80 + k); end
        // R2: bin boundaries
        cyc("R2", 0, 1, 0,    0, 0, 0, 0);
        cyc("R2", 0, 1, 2047, 0, 0, 0, 0);
        cyc("R2", 0, 1, 2048, 0, 0, 0, 0);
        cyc("R2", 0, 1, 4095, 0, 0, 0, 0);
        cyc("R2", 0, 1, 63487, 0, 0, 0, 0);
        rd("R2 bin0", 'h60); rd("R2 bin1", 'h61); rd("R2 bin2", 'h62); rd("R2 bin30", 'h7E);
        // R3: clamp to last bin
        cyc("R3", 0, 0, 0, 1, 65535, 0, 0);
        cyc("R3", 0, 0, 0, 1, 65536, 0, 0);
        cyc("R3", 0, 0, 0, 1, 1048575, 0, 0);
        rd("R3 bin31", 'h9F); rd("R3 bin0 data", 'h80);
        // R6: unmapped offsets read zero, windows edges
        rd("R6 below", 'h5F); rd("R6 above", 'hA0); rd("R6 between", 'h00); rd("R6 top", 'hFF);
        rd("R6 sc31", 'h7F); rd("R6 dt0", 'h80);
        // R8: both strobes same cycle, same bin index
        cyc("R8", 0, 1, 9000, 1, 9100, 0, 0);
        rd("R8 sc", 'h64); rd("R8 dt", 'h84);
        // R9: read and increment hitting the same bin in one cycle
        cyc("R9", 0, 1, 10000, 0, 0, 1, 'h64);
        rd("R9 after", 'h64);
        cyc("R9 dt", 0, 0, 0, 1, 10000, 1, 'h84);
        // R9: hold while rd_en low
        cyc("R9 hold", 0, 1, 100, 1, 100, 0, 0);
        cyc("R9 hold", 0, 0, 0, 0, 0, 0, 'h60);
        // R4: idle cycles change nothing
        repeat (3) cyc("R4", 0, 0, 0, 0, 0, 0, 0);
        rd("R4 sc bin0", 'h60); rd("R4 dt bin31", 'h9F);
        // R5: saturation
        for (int i = 0; i < CMAX + 8; i++) cyc("R5", 0, 1, 11000, 0, 0, 0, 0);
        rd("R5 saturated", 'h65);
        cyc("R5 held", 0, 1, 11000, 0, 0, 1, 'h65);
        rd("R5 held", 'h65);
        // R7: clear with concurrent strobes and read
        cyc("R7", 1, 1, 11000, 1, 500, 1, 'h65);
        rd("R7 sc", 'h65); rd("R7 dt", 'h80); rd("R7 sc bin0", 'h60);
        // Random mix of everything
        for (int i = 0; i < 1500; i++) begin
            cyc("R4 R7 R9 mix", ($urandom_range(0, 60) == 0),
                $urandom_range(0, 1) == 1, $urandom_range(0, 70000),
                $urandom_range(0, 1) == 1, $urandom_range(0, 70000),
                $urandom_range(0, 2) != 0, $urandom_range(0, 255));
        end
        for (int k = 0; k < NB; k++) begin rd("R2 final", 'h60 + k); rd("R2 final", 'h80 + k); end
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule